// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Controller

This block sits on the processor side of a shared 16-bit address/data bus that also has four upper lines, which carry either address or status. An internal request port supplies one transfer at a time: direction, memory or port space, a 20-bit address, write data, a high-byte enable, a segment selector code and the interrupt-enable flag. The controller turns each request into a bus cycle of four phases, T1 to T4. T1 carries the address and an address-latch strobe. T2 and T3 carry data and the read or write strobe. Wait phases are added after T3 for as long as the slave holds its ready input low. T4 ends the cycle.

Another bus master can ask for the bus with a hold input. The controller grants it only between cycles and never ends a running cycle early. It then raises a grant output and clears every output-enable flag, so the other master can drive the pins. Read data is captured at the end of the last strobe phase and returned on the request port during T4. A new request may be accepted in T4, so cycles can run back to back.

Top module: `mbus_ctrl`

## Requirements
- R1: In T1, `ale` is 1 and `ad_oe` is 1. `ad_out` carries address bits 15..0. `as_out` carries address bits 19..16 for memory cycles and 0000 for port cycles. `bhe_n` is the inverse of the request's high-byte enable.
- R2: From T2 through T4, `as_out` is {1'b0, ie, seg[1:0]}, so bit 3 is always low, bit 2 is the interrupt-enable flag and bits 1..0 are the segment code. `bhe_n` carries the status level S7_LEVEL (default 1). `ad_oe` is 1 only for writes, and then `ad_out` holds the write data.
- R3: `ale` is high for exactly one clock per bus cycle, and never for two clocks in a row.
- R4: `m_io` is 1 for memory and 0 for port cycles. `dt_r` is 1 for writes and 0 for reads. Both stay stable from T1 to the end of T4.
- R5: `rd_n` is low in T2, T3 and any wait phase of a read, and high at all other times. `wr_n` behaves the same way for writes. The two are never low together.
- R6: `den_n` is low from T2 through T4 and high in T1, while idle and while the bus is granted away.
- R7: `ready` is sampled at the end of T3 and at the end of each wait phase. While it is low, the controller adds wait phases in which the strobes, `ad_out` and `as_out` do not change. A high sample moves the cycle to T4.
- R8: For a read, `ad_in` is captured on the clock edge where `ready` is sampled high. It appears on `rsp_rdata` with `rsp_valid` high for exactly the T4 clock. `rsp_valid` stays low for writes.
- R9: If `hold` rises during a cycle, the cycle still completes. `hlda` goes high on the clock after T4, or on the clock after `hold` rises when the bus is idle. While `hlda` is high, `ad_oe`, `as_oe`, `bhe_oe` and `ctl_oe` are all 0.
- R10: When `hold` is low during a granted clock, `hlda` falls on the next clock. No T1 (`ale` high) happens in that same clock; a waiting request starts T1 one clock later.
- R11: After reset the controller is idle: `ale` 0, `rd_n` 1, `wr_n` 1, `den_n` 1, `hlda` 0, `rsp_valid` 0, `ad_oe` 0, and `req_ready` 1 while `hold` is low.
- R12: `req_ready` is 1 only while idle or in T4 with `hold` low. A request accepted in T4 starts its T1 on the next clock, with no idle clock in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this clock |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mem | input | 1 | 1 = memory, 0 = port space |
| req_addr | input | 20 | Transfer address |
| req_wdata | input | 16 | Write data |
| req_hi_en | input | 1 | High byte enabled |
| req_seg | input | 2 | Segment selector status code |
| req_ie | input | 1 | Interrupt-enable flag for status |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 16 | Captured read data |
| ad_out | output | 16 | Address/data value driven |
| ad_oe | output | 1 | Drive enable for ad_out |
| ad_in | input | 16 | Address/data value sampled |
| as_out | output | 4 | Upper address / status lines |
| as_oe | output | 1 | Drive enable for as_out |
| bhe_n | output | 1 | High-byte enable (T1) / S7 status |
| bhe_oe | output | 1 | Drive enable for bhe_n |
| ale | output | 1 | Address latch strobe |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| m_io | output | 1 | Memory (1) or port (0) |
| dt_r | output | 1 | Transmit (1) or receive (0) |
| den_n | output | 1 | Transceiver enable, active low |
| ctl_oe | output | 1 | Drive enable for strobes, m_io, dt_r, den_n |
| ready | input | 1 | Slave ready |
| hold | input | 1 | Bus request from another master |
| hlda | output | 1 | Bus granted to the other master |

## Verification
Some rules are checked by the assertions on every clock. These are the single-clock ALE pulse, the exclusive strobes, released enables under grant, the one-clock fall of the grant, frozen pins during wait phases, stable `m_io`/`dt_r` across a cycle, no grant straight after a strobe phase, and where responses and request acceptance may occur. Other behaviour depends on what the request asked for, so only the directed scenarios can show it. That covers the exact address and status values on the pins in each phase, the difference between port and memory upper bits, the captured read value, the number of wait phases, the one-clock gap after a grant ends, and the back-to-back start from T4.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

    localparam int ADDR_W = 20;
    localparam int DATA_W = 16;
    localparam int LOW_W  = 16;
    localparam int HI_W   = ADDR_W - LOW_W;
    localparam int SEG_W  = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_T1,
        ST_T2,
        ST_T3,
        ST_TW,
        ST_T4,
        ST_HELD
    } bus_state_e;

    typedef struct packed {
        logic              write;
        logic              mem;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              hi_en;
        logic [SEG_W-1:0]  seg;
        logic              ie;
    } bus_req_t;

    function automatic logic in_cycle(bus_state_e st);
        return (st == ST_T1) || (st == ST_T2) || (st == ST_T3) ||
               (st == ST_TW) || (st == ST_T4);
    endfunction

    function automatic logic strobe_phase(bus_state_e st);
        return (st == ST_T2) || (st == ST_T3) || (st == ST_TW);
    endfunction

    function automatic logic data_phase(bus_state_e st);
        return strobe_phase(st) || (st == ST_T4);
    endfunction

    function automatic logic [HI_W-1:0] upper_addr(bus_req_t r);
        return r.mem ? r.addr[ADDR_W-1:LOW_W] : '0;
    endfunction

    function automatic logic [HI_W-1:0] status_bits(bus_req_t r);
        logic [HI_W-1:0] s;
        s = '0;
        s[SEG_W-1:0] = r.seg;
        s[SEG_W]     = r.ie;
        return s;
    endfunction

endpackage

// File: rtl/mbus_fsm.sv
module mbus_fsm
    import mbus_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       hold,
    input  logic       ready,
    output bus_state_e state,
    output logic       can_start
);

    bus_state_e nxt;
    logic       boundary;

    assign boundary  = (state == ST_IDLE) || (state == ST_T4);
    assign can_start = boundary && !hold;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: nxt = hold ? ST_HELD : (start ? ST_T1 : ST_IDLE);
            ST_T1:   nxt = ST_T2;
            ST_T2:   nxt = ST_T3;
            ST_T3:   nxt = ready ? ST_T4 : ST_TW;
            ST_TW:   nxt = ready ? ST_T4 : ST_TW;
            ST_T4:   nxt = hold ? ST_HELD : (start ? ST_T1 : ST_IDLE);
            ST_HELD: nxt = hold ? ST_HELD : ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

endmodule

// File: rtl/mbus_latch.sv
module mbus_latch
    import mbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  bus_req_t          req_in,
    input  bus_state_e        state,
    input  logic              ready,
    input  logic [DATA_W-1:0] ad_in,
    output bus_req_t          cur,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);

    logic capture;

    assign capture = ((state == ST_T3) || (state == ST_TW)) && ready && !cur.write;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur       <= '0;
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            if (start) cur <= req_in;
            rsp_valid <= capture;
            if (capture) rsp_rdata <= ad_in;
        end
    end

endmodule

// File: rtl/mbus_drive.sv
module mbus_drive
    import mbus_pkg::*;
#(
    parameter logic S7_LEVEL = 1'b1
) (
    input  bus_state_e        state,
    input  bus_req_t          cur,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    output logic [HI_W-1:0]   as_out,
    output logic              as_oe,
    output logic              bhe_n,
    output logic              bhe_oe,
    output logic              ale,
    output logic              rd_n,
    output logic              wr_n,
    output logic              m_io,
    output logic              dt_r,
    output logic              den_n,
    output logic              ctl_oe,
    output logic              hlda
);

    logic t1;
    logic held;

    assign t1   = (state == ST_T1);
    assign held = (state == ST_HELD);

    always_comb begin
        ale    = t1;
        hlda   = held;
        ctl_oe = !held;
        as_oe  = in_cycle(state);
        bhe_oe = in_cycle(state);
        ad_oe  = t1 || (data_phase(state) && cur.write);
        ad_out = t1 ? cur.addr[LOW_W-1:0] : cur.wdata;
        as_out = t1 ? upper_addr(cur) : status_bits(cur);
        bhe_n  = t1 ? !cur.hi_en : S7_LEVEL;
        rd_n   = !(strobe_phase(state) && !cur.write);
        wr_n   = !(strobe_phase(state) && cur.write);
        den_n  = !data_phase(state);
        m_io   = cur.mem;
        dt_r   = cur.write;
    end

endmodule

// File: rtl/mbus_ctrl.sv
module mbus_ctrl
    import mbus_pkg::*;
#(
    parameter logic S7_LEVEL = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic              req_mem,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_hi_en,
    input  logic [SEG_W-1:0]  req_seg,
    input  logic              req_ie,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    input  logic [DATA_W-1:0] ad_in,
    output logic [HI_W-1:0]   as_out,
    output logic              as_oe,
    output logic              bhe_n,
    output logic              bhe_oe,
    output logic              ale,
    output logic              rd_n,
    output logic              wr_n,
    output logic              m_io,
    output logic              dt_r,
    output logic              den_n,
    output logic              ctl_oe,
    input  logic              ready,
    input  logic              hold,
    output logic              hlda
);

    bus_state_e state;
    bus_req_t   req_in;
    bus_req_t   cur;
    logic       can_start;
    logic       start;

    assign req_in = '{write: req_write, mem: req_mem, addr: req_addr,
                      wdata: req_wdata, hi_en: req_hi_en, seg: req_seg,
                      ie: req_ie};
    assign req_ready = can_start;
    assign start     = req_valid && can_start;

    mbus_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .hold      (hold),
        .ready     (ready),
        .state     (state),
        .can_start (can_start)
    );

    mbus_latch u_latch (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .req_in    (req_in),
        .state     (state),
        .ready     (ready),
        .ad_in     (ad_in),
        .cur       (cur),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

    mbus_drive #(.S7_LEVEL(S7_LEVEL)) u_drive (
        .state  (state),
        .cur    (cur),
        .ad_out (ad_out),
        .ad_oe  (ad_oe),
        .as_out (as_out),
        .as_oe  (as_oe),
        .bhe_n  (bhe_n),
        .bhe_oe (bhe_oe),
        .ale    (ale),
        .rd_n   (rd_n),
        .wr_n   (wr_n),
        .m_io   (m_io),
        .dt_r   (dt_r),
        .den_n  (den_n),
        .ctl_oe (ctl_oe),
        .hlda   (hlda)
    );

endmodule

// File: rtl/mbus_ctrl_chk.sv
module mbus_ctrl_chk
    import mbus_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              hold,
    input logic              ready,
    input logic              hlda,
    input logic              ale,
    input logic              rd_n,
    input logic              wr_n,
    input logic              den_n,
    input logic              m_io,
    input logic              dt_r,
    input logic              ad_oe,
    input logic              as_oe,
    input logic              bhe_oe,
    input logic              ctl_oe,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [DATA_W-1:0] ad_out,
    input logic [HI_W-1:0]   as_out
);

    AST_ALE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        ale |=> !ale);  // R3

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(!rd_n && !wr_n));  // R5

    AST_GRANT_RELEASE: assert property (@(posedge clk) disable iff (rst)
        hlda |-> (!ad_oe && !as_oe && !bhe_oe && !ctl_oe));  // R9

    AST_STROBE_NO_GRANT: assert property (@(posedge clk) disable iff (rst)
        (!rd_n || !wr_n) |=> !hlda);  // R9

    AST_GRANT_DROP: assert property (@(posedge clk) disable iff (rst)
        (hlda && !hold) |=> !hlda);  // R10

    AST_NO_T1_ON_REGAIN: assert property (@(posedge clk) disable iff (rst)
        $fell(hlda) |-> !ale);  // R10

    AST_WAIT_FROZEN: assert property (@(posedge clk) disable iff (rst)
        ((!rd_n || !wr_n) && !ready) |=>
            ($stable(rd_n) && $stable(wr_n) && $stable(ad_out) && $stable(as_out)));  // R7

    AST_DIR_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!den_n && $past(!den_n)) |-> ($stable(m_io) && $stable(dt_r)));  // R4

    AST_RSP_IN_T4: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (!den_n && rd_n && wr_n && !dt_r));  // R8

    AST_ACCEPT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (!hlda && rd_n && wr_n && !ale));  // R12

endmodule

bind mbus_ctrl mbus_ctrl_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .hold      (hold),
    .ready     (ready),
    .hlda      (hlda),
    .ale       (ale),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .den_n     (den_n),
    .m_io      (m_io),
    .dt_r      (dt_r),
    .ad_oe     (ad_oe),
    .as_oe     (as_oe),
    .bhe_oe    (bhe_oe),
    .ctl_oe    (ctl_oe),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .ad_out    (ad_out),
    .as_out    (as_out)
);

// File: tb/mbus_ctrl_bench.sv
module mbus_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_ready, req_write, req_mem, req_hi_en, req_ie;
    logic [19:0] req_addr;
    logic [15:0] req_wdata;
    logic [1:0]  req_seg;
    logic        rsp_valid;
    logic [15:0] rsp_rdata, ad_out, ad_in;
    logic        ad_oe, as_oe, bhe_n, bhe_oe, ale, rd_n, wr_n, m_io, dt_r;
    logic        den_n, ctl_oe, ready, hold, hlda;
    logic [3:0]  as_out;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    mbus_ctrl u_mbus_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_mem(req_mem), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_hi_en(req_hi_en), .req_seg(req_seg),
        .req_ie(req_ie), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in), .as_out(as_out),
        .as_oe(as_oe), .bhe_n(bhe_n), .bhe_oe(bhe_oe), .ale(ale),
        .rd_n(rd_n), .wr_n(wr_n), .m_io(m_io), .dt_r(dt_r), .den_n(den_n),
        .ctl_oe(ctl_oe), .ready(ready), .hold(hold), .hlda(hlda)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic set_req(input bit wr, input bit mem, input logic [19:0] a,
                           input logic [15:0] wd, input bit hi,
                           input logic [1:0] sg, input bit ie);
        req_write = wr; req_mem = mem; req_addr = a; req_wdata = wd;
        req_hi_en = hi; req_seg = sg; req_ie = ie;
    endtask

    // Full cycle walk; optional hold raised in T2.
    task automatic do_cycle(input bit wr, input bit mem, input logic [19:0] a,
                            input logic [15:0] wd, input bit hi,
                            input logic [1:0] sg, input bit ie, input int nw,
                            input logic [15:0] rdat, input bit hold_t2);
        logic [3:0] st;
        st = {1'b0, ie, sg};
        @(negedge clk);
        chk("R12 ready idle", req_ready, 1);
        set_req(wr, mem, a, wd, hi, sg, ie);
        req_valid = 1'b1;
        @(negedge clk);  // T1
        req_valid = 1'b0;
        chk("R1 ale", ale, 1);
        chk("R1 ad_oe", ad_oe, 1);
        chk("R1 ad_out", ad_out, a[15:0]);
        chk("R1 as_out", as_out, mem ? a[19:16] : 4'h0);
        chk("R1 bhe_n", bhe_n, !hi);
        chk("R6 den T1", den_n, 1);
        chk("R4 m_io", m_io, mem);
        chk("R4 dt_r", dt_r, wr);
        @(negedge clk);  // T2
        if (hold_t2) hold = 1'b1;
        chk("R3 ale T2", ale, 0);
        chk("R2 as_out", as_out, st);
        chk("R2 bhe S7", bhe_n, 1);
        chk("R2 ad_oe", ad_oe, wr);
        if (wr) chk("R2 wdata", ad_out, wd);
        chk("R5 rd_n T2", rd_n, wr);
        chk("R5 wr_n T2", wr_n, !wr);
        chk("R6 den T2", den_n, 0);
        chk("R12 busy", req_ready, 0);
        @(negedge clk);  // T3
        chk("R5 rd_n T3", rd_n, wr);
        chk("R5 wr_n T3", wr_n, !wr);
        ready = (nw == 0);
        ad_in = (nw == 0) ? rdat : 16'hBAD0;
        for (int w = 0; w < nw; w++) begin
            @(negedge clk);  // wait phase
            chk("R7 wait rd_n", rd_n, wr);
            chk("R7 wait wr_n", wr_n, !wr);
            chk("R7 wait as_out", as_out, st);
            chk("R7 wait ale", ale, 0);
            ready = (w == nw - 1);
            ad_in = (w == nw - 1) ? rdat : 16'hBAD1;
        end
        @(negedge clk);  // T4
        ready = 1'b1;
        ad_in = 16'hFFFF;
        chk("R5 rd_n T4", rd_n, 1);
        chk("R5 wr_n T4", wr_n, 1);
        chk("R6 den T4", den_n, 0);
        chk("R8 rsp_valid", rsp_valid, !wr);
        if (!wr) chk("R8 rdata", rsp_rdata, rdat);
        chk("R4 m_io T4", m_io, mem);
        chk("R9 no early grant", hlda, 0);
        @(negedge clk);  // idle or granted
        chk("R8 rsp pulse", rsp_valid, 0);
        chk("R6 den after", den_n, 1);
        chk("R3 ale after", ale, 0);
    endtask

    task automatic test_reset;
        rst = 1'b1; req_valid = 1'b0; ready = 1'b1; hold = 1'b0; ad_in = '0;
        set_req(0, 0, '0, '0, 0, '0, 0);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R11 ale", ale, 0);
        chk("R11 rd_n", rd_n, 1);
        chk("R11 wr_n", wr_n, 1);
        chk("R11 den_n", den_n, 1);
        chk("R11 hlda", hlda, 0);
        chk("R11 rsp_valid", rsp_valid, 0);
        chk("R11 ad_oe", ad_oe, 0);
        chk("R11 req_ready", req_ready, 1);
    endtask

    task automatic test_hold_mid;
        do_cycle(1, 1, 20'hABCDE, 16'h1357, 1, 2'd3, 0, 1, 16'h0, 1);
        // granted clock
        req_valid = 1'b1;
        set_req(0, 1, 20'h54321, 16'h0, 0, 2'd1, 1);
        #0;
        chk("R9 hlda", hlda, 1);
        chk("R9 ad_oe", ad_oe, 0);
        chk("R9 as_oe", as_oe, 0);
        chk("R9 bhe_oe", bhe_oe, 0);
        chk("R9 ctl_oe", ctl_oe, 0);
        chk("R12 no accept held", req_ready, 0);
        @(negedge clk);
        chk("R9 still held", hlda, 1);
        hold = 1'b0;
        @(negedge clk);
        chk("R10 hlda fell", hlda, 0);
        chk("R10 no T1 yet", ale, 0);
        chk("R10 ctl_oe back", ctl_oe, 1);
        @(negedge clk);
        chk("R10 T1 after", ale, 1);
        chk("R10 addr", ad_out, 16'h4321);
        req_valid = 1'b0;
        repeat (4) @(negedge clk);
        chk("R10 back idle", den_n, 1);
    endtask

    task automatic test_hold_idle;
        @(negedge clk);
        hold = 1'b1;
        @(negedge clk);
        chk("R9 idle grant", hlda, 1);
        chk("R9 idle ctl_oe", ctl_oe, 0);
        chk("R9 idle rd_n", rd_n, 1);
        hold = 1'b0;
        @(negedge clk);
        chk("R10 idle release", hlda, 0);
    endtask

    task automatic test_back_to_back;
        @(negedge clk);
        set_req(0, 0, 20'hF1234, 16'h0, 0, 2'd0, 0);
        req_valid = 1'b1;
        @(negedge clk);  // T1 of A
        chk("R1 io upper zero", as_out, 4'h0);
        set_req(1, 1, 20'h9A5A5, 16'hC3C3, 1, 2'd2, 1);
        @(negedge clk);  // T2
        chk("R12 busy T2", req_ready, 0);
        @(negedge clk);  // T3
        ad_in = 16'h7E7E;
        @(negedge clk);  // T4
        chk("R8 io read", rsp_rdata, 16'h7E7E);
        chk("R12 accept T4", req_ready, 1);
        @(negedge clk);  // T1 of B
        req_valid = 1'b0;
        chk("R12 b2b ale", ale, 1);
        chk("R12 b2b addr", ad_out, 16'hA5A5);
        chk("R12 b2b upper", as_out, 4'h9);
        @(negedge clk);
        chk("R2 b2b status", as_out, 4'b0110);
        repeat (3) @(negedge clk);
        chk("R3 b2b done", ale, 0);
    endtask

    initial begin
        test_reset();
        do_cycle(0, 1, 20'h3C0F0, 16'h0, 1, 2'd1, 1, 0, 16'hBEEF, 0);
        do_cycle(1, 0, 20'h80042, 16'h55AA, 0, 2'd2, 0, 0, 16'h0, 0);
        do_cycle(0, 0, 20'h00380, 16'h0, 0, 2'd0, 1, 3, 16'h1234, 0);
        do_cycle(1, 1, 20'hFFFFE, 16'hA1B2, 1, 2'd3, 1, 2, 16'h0, 0);
        test_hold_mid();
        test_hold_idle();
        test_back_to_back();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule